// File: doc/BRIEF.md
# ROM-to-RAM shadowing controller

This block drives the memory strobes of a small processor board on which a boot ROM and a RAM occupy the same address range. After reset it is in shadow mode. A processor read in that range is served by the ROM. The RAM write enable is pulsed with the same read, so the RAM captures the data on the bus at the same address. Software fills the RAM simply by reading through the range once. Explicit processor writes to the range also land in RAM in this mode.

A single control bit, written through the bit-serial I/O output interface, moves the block to run mode. From then on the ROM is never enabled, and the RAM serves both reads and writes. The bit stays set until the next reset.

Every ROM read cycle requests one wait state from the processor, because the ROM is slow. All outputs come from registers, so they are free of glitches relative to the strobes. Each output takes effect one clock after the inputs that cause it.

Top module: `rom_shadow_ctrl`

## Requirements
- R1: While `rst_n` is low, `rom_oe_n`, `ram_oe_n`, `ram_we_n` and `ram_ce_n` are 1 and `wait_req` is 0. Reset also returns the block to shadow mode.
- R2: In shadow mode, with `mem_sel`=1 and `rd_n`=0, the next clock gives `rom_oe_n`=0 and `ram_we_n`=0, while `ram_oe_n` stays 1.
- R3: In shadow mode, with `mem_sel`=1, `wr_n`=0 and `rd_n`=1, the next clock gives `ram_we_n`=0, with `rom_oe_n`=1 and `ram_oe_n`=1. The RAM output enable is never 0 in shadow mode.
- R4: In run mode, `rom_oe_n` is 1. With `mem_sel`=1, the next clock gives `ram_oe_n` equal to `rd_n` and `ram_we_n` equal to `wr_n`.
- R5: The block enters run mode at the clock edge where `io_wr`=1, `io_addr` equals parameter `MODE_ADDR` (default 0) and `io_bit`=1. A cycle with a different address, with `io_bit`=0, or with `io_wr`=0 leaves the mode unchanged. Run mode is left only by reset.
- R6: `wait_req` is 1 for exactly one clock per ROM read cycle. That clock is the first one in which `rom_oe_n` is 0. `wait_req` is never 1 in run mode.
- R7: `ram_ce_n` is 0 exactly when `ram_oe_n` or `ram_we_n` is 0. With `mem_sel`=0, the next clock gives 1 on all four enables and 0 on `wait_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| mem_sel | input | 1 | Access falls in the shared ROM/RAM range |
| io_wr | input | 1 | Bit I/O output cycle, valid for this clock |
| io_addr | input | IO_AW | Bit I/O address |
| io_bit | input | 1 | Bit I/O output value |
| rom_oe_n | output | 1 | ROM output enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| wait_req | output | 1 | Wait-state request to the processor |

## Verification
Every strobe output and `wait_req` is due one clock after the inputs that cause it. A mode-bit write takes effect on the outputs one clock after that, as the first access that follows shows. The bench applies inputs on the falling edge and compares outputs on the next falling edge, after exactly one rising edge. Each access is preceded by an idle cycle, so the first comparison of an access expects the wait state and a repeat of the same inputs expects none. The full strobe space is swept in both modes, with expected vectors worked out arithmetically from the mode, `mem_sel`, `rd_n` and `wr_n`.

// File: rtl/rom_shadow_ctrl.sv
module rom_shadow_ctrl #(
  parameter int IO_AW = 12,
  parameter int unsigned MODE_ADDR = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             mem_sel,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_bit,
  output logic             rom_oe_n,
  output logic             ram_oe_n,
  output logic             ram_we_n,
  output logic             ram_ce_n,
  output logic             wait_req
);
  localparam logic [IO_AW-1:0] ModeSel = IO_AW'(MODE_ADDR);

  logic run_q, rom_rd_q;
  logic rd_hit, wr_hit, rom_rd, set_run;
  logic rom_oe_d, ram_oe_d, ram_we_d;

  assign rd_hit   = mem_sel & ~rd_n;
  assign wr_hit   = mem_sel & ~wr_n;
  assign rom_rd   = ~run_q & rd_hit;
  assign set_run  = io_wr & io_bit & (io_addr == ModeSel);

  assign rom_oe_d = ~rom_rd;
  assign ram_oe_d = ~(run_q & rd_hit);
  assign ram_we_d = ~(wr_hit | rom_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      rom_rd_q <= 1'b0;
      rom_oe_n <= 1'b1;
      ram_oe_n <= 1'b1;
      ram_we_n <= 1'b1;
      ram_ce_n <= 1'b1;
      wait_req <= 1'b0;
    end else begin
      if (set_run) run_q <= 1'b1;
      rom_rd_q <= rom_rd;
      rom_oe_n <= rom_oe_d;
      ram_oe_n <= ram_oe_d;
      ram_we_n <= ram_we_d;
      ram_ce_n <= ram_oe_d & ram_we_d;
      wait_req <= rom_rd & ~rom_rd_q;
    end
  end
endmodule

module rom_shadow_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_n,
  input logic wr_n,
  input logic mem_sel,
  input logic run_q,
  input logic rom_oe_n,
  input logic ram_oe_n,
  input logic ram_we_n,
  input logic ram_ce_n,
  input logic wait_req
);
  always @(negedge clk)
    if (!rst_n)
      p_reset_idle_r1: assert (rom_oe_n && ram_oe_n && ram_we_n && ram_ce_n && !wait_req);

  p_shadow_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_q && mem_sel && !rd_n) |-> !rom_oe_n && !ram_we_n && ram_oe_n);

  p_no_contention_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_oe_n && !ram_oe_n));

  p_run_rom_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q) |-> rom_oe_n && !wait_req);

  p_mode_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  p_wait_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |=> !wait_req);

  p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_sel) |-> rom_oe_n && ram_oe_n && ram_we_n && ram_ce_n && !wait_req);
endmodule

bind rom_shadow_ctrl rom_shadow_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .mem_sel(mem_sel),
  .run_q(run_q), .rom_oe_n(rom_oe_n), .ram_oe_n(ram_oe_n),
  .ram_we_n(ram_we_n), .ram_ce_n(ram_ce_n), .wait_req(wait_req)
);

// File: tb/rom_shadow_ctrl_bench.sv
`timescale 1ns/1ps
module rom_shadow_ctrl_bench;
  localparam int AW = 12;
  localparam int unsigned MA = 12'h005;

  logic clk = 0, rst_n = 0;
  logic rd_n = 1, wr_n = 1, mem_sel = 0, io_wr = 0, io_bit = 0;
  logic [AW-1:0] io_addr = '0;
  logic rom_oe_n, ram_oe_n, ram_we_n, ram_ce_n, wait_req;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  rom_shadow_ctrl #(.IO_AW(AW), .MODE_ADDR(MA)) u_rom_shadow_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .mem_sel(mem_sel),
    .io_wr(io_wr), .io_addr(io_addr), .io_bit(io_bit),
    .rom_oe_n(rom_oe_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_ce_n(ram_ce_n), .wait_req(wait_req));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [4:0] expv(bit run, bit sel, bit rd, bit wr, bit first);
    bit ro, mo, mw;
    if (!sel) return 5'b11110;
    ro = run ? 1'b1 : rd;
    mo = run ? rd : 1'b1;
    mw = run ? wr : (rd & wr);
    return {ro, mo, mw, mo & mw, (!run && !rd && first)};
  endfunction

  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {rom_oe_n, ram_oe_n, ram_we_n, ram_ce_n, wait_req};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs {rom_oe_n,ram_oe_n,ram_we_n,ram_ce_n,wait_req} = %b, expected %b",
               req, act, exp);
    end
  endtask

  task automatic drive(bit sel, bit rd, bit wr);
    @(negedge clk);
    mem_sel = sel; rd_n = rd; wr_n = wr;
  endtask

  task automatic io_cycle(logic [AW-1:0] a, bit v, bit strobe);
    @(negedge clk);
    io_wr = strobe; io_addr = a; io_bit = v;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic sweep(bit run, string req);
    for (int c = 0; c < 8; c++) begin
      bit sel, rd, wr;
      {sel, rd, wr} = c[2:0];
      drive(0, 1, 1);
      drive(sel, rd, wr);
      @(negedge clk);
      chk(req, expv(run, sel, rd, wr, 1'b1));
      @(negedge clk);
      chk(req, expv(run, sel, rd, wr, 1'b0));
    end
    drive(0, 1, 1);
  endtask

  task automatic probe_mode(bit run, string req);
    drive(0, 1, 1);
    drive(1, 0, 1);
    @(negedge clk);
    chk(req, expv(run, 1, 0, 1, 1'b1));
    drive(0, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 5'b11110);
    rst_n = 1;
    // R2 R3 R6 R7: shadow mode, all strobe combinations
    sweep(0, "R2/R3/R6/R7 shadow");
    // R5: cycles that must not set the mode
    io_cycle(AW'(MA + 1), 1, 1);
    probe_mode(0, "R5 wrong address ignored");
    io_cycle(AW'(MA), 0, 1);
    probe_mode(0, "R5 zero value ignored");
    io_cycle(AW'(MA), 1, 0);
    probe_mode(0, "R5 no strobe ignored");
    // R6: long ROM read gives a single wait clock
    drive(0, 1, 1);
    drive(1, 0, 1);
    @(negedge clk); chk("R6 long read first", expv(0, 1, 0, 1, 1'b1));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk("R6 long read held", expv(0, 1, 0, 1, 1'b0));
    end
    drive(0, 1, 1);
    // R5: enter run mode
    io_cycle(AW'(MA), 1, 1);
    probe_mode(1, "R5 mode set");
    // R4 R6 R7: run mode sweep
    sweep(1, "R4/R6/R7 run");
    io_cycle(AW'(MA), 0, 1);
    probe_mode(1, "R5 run is sticky");
    // R1: reset returns to shadow
    @(negedge clk); rst_n = 0;
    @(negedge clk); chk("R1 reset again", 5'b11110);
    rst_n = 1;
    probe_mode(0, "R1 reset restores shadow");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule